// File: doc/BRIEF.md
# Debounced GPIO Controller

A controller for a bank of general-purpose pins, driven through a simple word-addressed register port. Software holds the output level of each pin, its direction, a bypass flag and pull-up settings. The bypass and pull settings are not used inside the block: they go straight to pad outputs. Output bits can be changed one at a time without a read-modify-write, through separate set and clear registers.

Each input pin passes through a two-flop synchroniser. It can then pass through a debounce filter, which is clocked by a shared prescaler. The filtered level feeds an interrupt detector. For each pin, software chooses:
- edge or level triggering;
- the polarity (rising edge or high level, against falling edge or low level);
- whether both edges trigger.

Edge events are latched until software clears them. Level events follow the pin. Enable and mask registers select which raw bits reach the single combined interrupt line.

Top module: `gpio_dbc_top`

## Requirements
- R1: After reset every writable register reads 0, the pad outputs are 0, and the interrupt output is low.
- R2: A write at offset 0x00 loads the output data, which drives `padOut`. Offset 0x08 drives `padOutEn` (1 means output). Offsets 0x0C, 0x18 and 0x1C drive `padBypass`, `padPullEn` and `padPullHigh` (1 means pull high). Each of these registers reads back what was written.
- R3: A write at offset 0x10 sets each output data bit where the written bit is 1. Bits written 0 are left unchanged.
- R4: A write at offset 0x14 clears each output data bit where the written bit is 1. Bits written 0 are left unchanged.
- R5: Offset 0x04 reads the pad inputs after a two-flop synchroniser. A write to this offset has no effect.
- R6: When bit n of offset 0x34 is 0, pin n is edge triggered. If bit n of 0x3C is 0, a rising edge sets bit n of the raw state at 0x24; if it is 1, a falling edge sets it. The bit stays set until 1 is written to bit n of offset 0x30.
- R7: For an edge-triggered pin, bit n of offset 0x38 set to 1 makes both edges set the raw bit, whatever the polarity bit says.
- R8: When bit n of offset 0x34 is 1, pin n is level triggered. Its raw bit equals the pin level (polarity bit 0) or the inverted pin level (polarity bit 1), and it follows the pin.
- R9: The masked state at offset 0x28 is the raw state AND the enable register (0x20) AND NOT the mask register (0x2C). The interrupt output is the OR of all masked bits.
- R10: When bit n of offset 0x40 is 1, pin n is debounced. Bits 15:0 of offset 0x44 hold a prescale value P, and a tick occurs every P clocks. A new level is taken only when two successive ticks sample the same value, so a one-clock glitch is rejected.
- R11: When debouncing is enabled on a pin and the prescale value is 0, that pin never sets its raw bit. Pins without debouncing are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 7 | Byte offset of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| padIn | input | 32 | Pin input levels |
| padOut | output | 32 | Output data to the pads |
| padOutEn | output | 32 | Per-pin output enable |
| padBypass | output | 32 | Per-pin bypass flag |
| padPullEn | output | 32 | Per-pin pull enable |
| padPullHigh | output | 32 | Per-pin pull direction, 1 means high |
| irqOut | output | 1 | Combined interrupt |

## Verification
The assertions assume that `regAddr` and `regWdata` are stable while `regWrEn` is high. The bench changes the register port only on falling clock edges and holds each write for exactly one cycle. The assertions also assume that `padIn` is free of metastability after two flops. The bench drives the pins only on falling edges and keeps each level for at least one full cycle. The latch assertion only requires edge bits to hold while the trigger mode stays at edge, so the bench clears the raw state after each reconfiguration.

// File: rtl/gpio_dbc_pkg.sv
package gpio_dbc_pkg;

  localparam int ADDR_W = 7;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DOUT   = 7'h00,
    OFF_DIN    = 7'h04,
    OFF_DIR    = 7'h08,
    OFF_BYP    = 7'h0C,
    OFF_SET    = 7'h10,
    OFF_CLR    = 7'h14,
    OFF_PULLEN = 7'h18,
    OFF_PULLHI = 7'h1C,
    OFF_IEN    = 7'h20,
    OFF_IRAW   = 7'h24,
    OFF_IMSKD  = 7'h28,
    OFF_IMASK  = 7'h2C,
    OFF_ICLR   = 7'h30,
    OFF_TRIG   = 7'h34,
    OFF_BOTH   = 7'h38,
    OFF_POL    = 7'h3C,
    OFF_DBEN   = 7'h40,
    OFF_SCALE  = 7'h44
  } regOff_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;      // prescaler tick for debounce sampling
    logic clrEn;     // write to interrupt clear register this cycle
    logic blockAll;  // prescale is zero: debounced pins may not detect
  } pathStrobe_t;

endpackage

// File: rtl/gpio_dbc_ctrl.sv
module gpio_dbc_ctrl
  import gpio_dbc_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int SCALE_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_PINS-1:0] pinSync,
  input  logic [NUM_PINS-1:0] rawState,
  output logic [NUM_PINS-1:0] dataOut,
  output logic [NUM_PINS-1:0] dirOut,
  output logic [NUM_PINS-1:0] bypass,
  output logic [NUM_PINS-1:0] pullEn,
  output logic [NUM_PINS-1:0] pullHigh,
  output logic [NUM_PINS-1:0] intEn,
  output logic [NUM_PINS-1:0] intMask,
  output logic [NUM_PINS-1:0] trigLvl,
  output logic [NUM_PINS-1:0] trigBoth,
  output logic [NUM_PINS-1:0] trigPol,
  output logic [NUM_PINS-1:0] dbEn,
  output logic [NUM_PINS-1:0] maskedState,
  output pathStrobe_t         strobe
);

  logic [NUM_PINS-1:0] wData;
  logic [SCALE_W-1:0]  scale;
  logic [SCALE_W-1:0]  scaleCnt;
  logic                scaleZero;
  logic                tickNow;

  assign wData = regWdata[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      dirOut   <= '0;
      bypass   <= '0;
      pullEn   <= '0;
      pullHigh <= '0;
      intEn    <= '0;
      intMask  <= '0;
      trigLvl  <= '0;
      trigBoth <= '0;
      trigPol  <= '0;
      dbEn     <= '0;
      scale    <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        OFF_DOUT:   dataOut  <= wData;
        OFF_SET:    dataOut  <= dataOut | wData;
        OFF_CLR:    dataOut  <= dataOut & ~wData;
        OFF_DIR:    dirOut   <= wData;
        OFF_BYP:    bypass   <= wData;
        OFF_PULLEN: pullEn   <= wData;
        OFF_PULLHI: pullHigh <= wData;
        OFF_IEN:    intEn    <= wData;
        OFF_IMASK:  intMask  <= wData;
        OFF_TRIG:   trigLvl  <= wData;
        OFF_BOTH:   trigBoth <= wData;
        OFF_POL:    trigPol  <= wData;
        OFF_DBEN:   dbEn     <= wData;
        OFF_SCALE:  scale    <= regWdata[SCALE_W-1:0];
        default: ;
      endcase
    end
  end

  // shared debounce prescaler: one tick every 'scale' clocks
  assign scaleZero = (scale == '0);
  assign tickNow   = !scaleZero && (scaleCnt >= scale - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    scaleCnt <= '0;
    else if (scaleZero || tickNow) scaleCnt <= '0;
    else                          scaleCnt <= scaleCnt + 1'b1;
  end

  assign maskedState = rawState & intEn & ~intMask;

  always_comb begin
    strobe          = '0;
    strobe.tick     = tickNow;
    strobe.clrEn    = regWrEn && (regAddr == OFF_ICLR);
    strobe.blockAll = scaleZero;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFF_DOUT:   regRdata[NUM_PINS-1:0] = dataOut;
      OFF_DIN:    regRdata[NUM_PINS-1:0] = pinSync;
      OFF_DIR:    regRdata[NUM_PINS-1:0] = dirOut;
      OFF_BYP:    regRdata[NUM_PINS-1:0] = bypass;
      OFF_PULLEN: regRdata[NUM_PINS-1:0] = pullEn;
      OFF_PULLHI: regRdata[NUM_PINS-1:0] = pullHigh;
      OFF_IEN:    regRdata[NUM_PINS-1:0] = intEn;
      OFF_IRAW:   regRdata[NUM_PINS-1:0] = rawState;
      OFF_IMSKD:  regRdata[NUM_PINS-1:0] = maskedState;
      OFF_IMASK:  regRdata[NUM_PINS-1:0] = intMask;
      OFF_TRIG:   regRdata[NUM_PINS-1:0] = trigLvl;
      OFF_BOTH:   regRdata[NUM_PINS-1:0] = trigBoth;
      OFF_POL:    regRdata[NUM_PINS-1:0] = trigPol;
      OFF_DBEN:   regRdata[NUM_PINS-1:0] = dbEn;
      OFF_SCALE:  regRdata[SCALE_W-1:0]  = scale;
      default:    regRdata = '0;
    endcase
  end

  // R3: set register only raises bits
  assert_set_raises_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_SET) |=>
      ((dataOut & $past(wData)) == $past(wData)) &&
      ((dataOut & ~$past(wData)) == ($past(dataOut) & ~$past(wData))));

  // R4: clear register only lowers bits
  assert_clear_lowers_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_CLR) |=>
      ((dataOut & $past(wData)) == '0) &&
      ((dataOut & ~$past(wData)) == ($past(dataOut) & ~$past(wData))));

  // R10: no tick while prescale is zero
  assert_no_tick_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (scale == '0) |-> !strobe.tick);

endmodule

// File: rtl/gpio_dbc_path.sv
module gpio_dbc_path
  import gpio_dbc_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] padIn,
  input  pathStrobe_t         strobe,
  input  logic [NUM_PINS-1:0] clrData,
  input  logic [NUM_PINS-1:0] trigLvl,
  input  logic [NUM_PINS-1:0] trigBoth,
  input  logic [NUM_PINS-1:0] trigPol,
  input  logic [NUM_PINS-1:0] dbEn,
  output logic [NUM_PINS-1:0] pinSync,
  output logic [NUM_PINS-1:0] rawState
);

  logic [NUM_PINS-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_PINS-1:0] candLvl;
  logic [NUM_PINS-1:0] stableLvl;
  logic [NUM_PINS-1:0] sameBits;
  logic [NUM_PINS-1:0] filtLvl;
  logic [NUM_PINS-1:0] prevFilt;
  logic [NUM_PINS-1:0] riseEv;
  logic [NUM_PINS-1:0] fallEv;
  logic [NUM_PINS-1:0] edgeEv;
  logic [NUM_PINS-1:0] lvlAct;
  logic [NUM_PINS-1:0] blockVec;
  logic [NUM_PINS-1:0] clrBits;
  logic [NUM_PINS-1:0] nextRaw;

  // input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe[0] <= '0;
    else       syncPipe[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncPipe[s] <= '0;
      else       syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign pinSync = syncPipe[SYNC_STAGES-1];

  // debounce: take a level when two successive ticks agree
  assign sameBits = ~(pinSync ^ candLvl);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candLvl   <= '0;
      stableLvl <= '0;
    end else if (strobe.tick) begin
      candLvl   <= pinSync;
      stableLvl <= (sameBits & pinSync) | (~sameBits & stableLvl);
    end
  end

  assign filtLvl = (dbEn & stableLvl) | (~dbEn & pinSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevFilt <= '0;
    else       prevFilt <= filtLvl;
  end

  // detection
  assign riseEv   = filtLvl & ~prevFilt;
  assign fallEv   = ~filtLvl & prevFilt;
  assign edgeEv   = (trigBoth & (riseEv | fallEv)) |
                    (~trigBoth & ((~trigPol & riseEv) | (trigPol & fallEv)));
  assign lvlAct   = filtLvl ^ trigPol;
  assign blockVec = dbEn & {NUM_PINS{strobe.blockAll}};
  assign clrBits  = strobe.clrEn ? clrData : '0;

  // a new edge wins over a clear in the same cycle
  assign nextRaw = (trigLvl & lvlAct & ~blockVec) |
                   (~trigLvl & ((rawState & ~clrBits) | (edgeEv & ~blockVec)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawState <= '0;
    else       rawState <= nextRaw;
  end

  // R11: a blocked pin never gains a raw bit
  assert_blocked_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawState & ~$past(rawState) & $past(blockVec)) == '0));

  // R10: the debounced level moves only on a tick
  assert_stable_on_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(stableLvl));

  // R6: a latched edge bit holds unless cleared or the mode changes
  assert_edge_latched_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(rawState & ~trigLvl & ~clrBits) & ~trigLvl & ~rawState) == '0));

endmodule

// File: rtl/gpio_dbc_top.sv
module gpio_dbc_top
  import gpio_dbc_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int DATA_W      = 32,
  parameter int SCALE_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn,
  output logic [NUM_PINS-1:0] padBypass,
  output logic [NUM_PINS-1:0] padPullEn,
  output logic [NUM_PINS-1:0] padPullHigh,
  output logic                irqOut
);

  pathStrobe_t         strobe;
  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] rawState;
  logic [NUM_PINS-1:0] maskedState;
  logic [NUM_PINS-1:0] intEn;
  logic [NUM_PINS-1:0] intMask;
  logic [NUM_PINS-1:0] trigLvl;
  logic [NUM_PINS-1:0] trigBoth;
  logic [NUM_PINS-1:0] trigPol;
  logic [NUM_PINS-1:0] dbEn;

  gpio_dbc_ctrl #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .SCALE_W(SCALE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .pinSync(pinSync), .rawState(rawState),
    .dataOut(padOut), .dirOut(padOutEn), .bypass(padBypass),
    .pullEn(padPullEn), .pullHigh(padPullHigh),
    .intEn(intEn), .intMask(intMask),
    .trigLvl(trigLvl), .trigBoth(trigBoth), .trigPol(trigPol), .dbEn(dbEn),
    .maskedState(maskedState), .strobe(strobe)
  );

  gpio_dbc_path #(
    .NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk(clk), .rstN(rstN), .padIn(padIn), .strobe(strobe),
    .clrData(regWdata[NUM_PINS-1:0]),
    .trigLvl(trigLvl), .trigBoth(trigBoth), .trigPol(trigPol), .dbEn(dbEn),
    .pinSync(pinSync), .rawState(rawState)
  );

  assign irqOut = |maskedState;

  // R9: interrupt needs an enabled, unmasked raw bit
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((|intEn) && (|rawState) && ~(&intMask)));

endmodule

// File: tb/gpio_dbc_top_bench.sv
module gpio_dbc_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOutEn, padBypass, padPullEn, padPullHigh;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  gpio_dbc_top u_gpio_dbc_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn),
    .padOut(padOut), .padOutEn(padOutEn), .padBypass(padBypass),
    .padPullEn(padPullEn), .padPullHigh(padPullHigh), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int pin;
    logic expBit;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(7'h00, d); chk("R1 dout", d, 0);
    rd(7'h08, d); chk("R1 dir", d, 0);
    rd(7'h24, d); chk("R1 raw", d, 0);
    rd(7'h44, d); chk("R1 scale", d, 0);
    chk("R1 irq", {31'b0, irqOut}, 0);
    chk("R1 padOut", padOut, 0);

    // R2 plain registers and pass-through
    wr(7'h00, 32'hA5A5_0F0F); rd(7'h00, d); chk("R2 dout read", d, 32'hA5A5_0F0F);
    chk("R2 padOut", padOut, 32'hA5A5_0F0F);
    wr(7'h08, 32'h0000_FFFF); chk("R2 padOutEn", padOutEn, 32'h0000_FFFF);
    wr(7'h0C, 32'h1234_0000); chk("R2 padBypass", padBypass, 32'h1234_0000);
    wr(7'h18, 32'h00FF_00FF); chk("R2 padPullEn", padPullEn, 32'h00FF_00FF);
    wr(7'h1C, 32'hF0F0_F0F0); rd(7'h1C, d); chk("R2 pullHigh read", d, 32'hF0F0_F0F0);
    chk("R2 padPullHigh", padPullHigh, 32'hF0F0_F0F0);

    // R3 / R4 atomic set and clear
    wr(7'h10, 32'h0000_00F0); chk("R3 set", padOut, 32'hA5A5_0FFF);
    wr(7'h10, 32'h0000_0000); chk("R3 set zero", padOut, 32'hA5A5_0FFF);
    wr(7'h14, 32'hA000_000F); chk("R4 clear", padOut, 32'h05A5_0FF0);
    wr(7'h14, 32'h0000_0000); chk("R4 clear zero", padOut, 32'h05A5_0FF0);

    // R5 synchronised input, write ignored
    @(negedge clk); padIn = 32'h1234_5678;
    waitN(3);
    rd(7'h04, d); chk("R5 din", d, 32'h1234_5678);
    wr(7'h04, 32'hFFFF_FFFF); rd(7'h04, d); chk("R5 din write ignored", d, 32'h1234_5678);
    @(negedge clk); padIn = '0;
    waitN(4);

    // R6/R7/R8 sweep of trigger configurations on several pins
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic lvl, both, pol;
      lvl = cfg[2]; both = cfg[1]; pol = cfg[0];
      wr(7'h34, {32{lvl}});
      wr(7'h38, {32{both}});
      wr(7'h3C, {32{pol}});
      wr(7'h30, 32'hFFFF_FFFF);
      for (int pi = 0; pi < 3; pi++) begin
        pin = (pi == 0) ? 0 : (pi == 1) ? 7 : 31;
        wr(7'h30, 32'hFFFF_FFFF);
        @(negedge clk); padIn[pin] = 1'b1;
        waitN(4);
        rd(7'h24, d);
        expBit = lvl ? ~pol : (both | ~pol);
        chk(lvl ? "R8 level after rise" : (both ? "R7 both after rise" : "R6 edge after rise"),
            {31'b0, d[pin]}, {31'b0, expBit});
        @(negedge clk); padIn[pin] = 1'b0;
        waitN(4);
        rd(7'h24, d);
        expBit = lvl ? pol : (both | 1'b1);
        chk(lvl ? "R8 level after fall" : (both ? "R7 both after fall" : "R6 edge latched"),
            {31'b0, d[pin]}, {31'b0, expBit});
        if (!lvl) begin
          wr(7'h30, 32'h1 << pin);
          rd(7'h24, d);
          chk("R6 cleared", {31'b0, d[pin]}, 0);
        end
      end
    end

    // R9 enable and mask combinations
    wr(7'h34, 0); wr(7'h38, 0); wr(7'h3C, 0);
    wr(7'h30, 32'hFFFF_FFFF);
    @(negedge clk); padIn[0] = 1'b1;
    waitN(4);
    for (int c = 0; c < 4; c++) begin
      wr(7'h20, {31'b0, c[0]});
      wr(7'h2C, {31'b0, c[1]});
      rd(7'h28, d);
      chk("R9 masked", d, {31'b0, c[0] & ~c[1]});
      chk("R9 irq", {31'b0, irqOut}, {31'b0, c[0] & ~c[1]});
    end
    wr(7'h20, 0); wr(7'h2C, 0);
    @(negedge clk); padIn[0] = 1'b0;

    // R10 debounce on pin 5, prescale 4
    wr(7'h40, 32'h20);
    wr(7'h44, 32'h4);
    waitN(4);
    wr(7'h30, 32'hFFFF_FFFF);
    @(negedge clk); padIn[5] = 1'b1;
    @(negedge clk); padIn[5] = 1'b0;
    waitN(20);
    rd(7'h24, d); chk("R10 glitch rejected", {31'b0, d[5]}, 0);
    @(negedge clk); padIn[5] = 1'b1;
    waitN(2);
    rd(7'h24, d); chk("R10 not yet accepted", {31'b0, d[5]}, 0);
    waitN(16);
    rd(7'h24, d); chk("R10 accepted", {31'b0, d[5]}, 1);
    @(negedge clk); padIn[5] = 1'b0;
    waitN(20);

    // R11 zero prescale blocks debounced pin only
    wr(7'h44, 0);
    wr(7'h30, 32'hFFFF_FFFF);
    @(negedge clk); padIn[5] = 1'b1; padIn[6] = 1'b1;
    waitN(20);
    rd(7'h24, d);
    chk("R11 debounced pin blocked", {31'b0, d[5]}, 0);
    chk("R11 plain pin detects", {31'b0, d[6]}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule